// File: doc/BRIEF.md
# Addressable Cascadable Shift-Register Delay Line

This block delays a one-bit serial stream by a number of clock cycles that can be chosen while it runs. Storage is a row of plain shift stages with no reset. One storage cell has 32 stages. Bits move one stage on each rising clock edge, but only while the clock enable is high. A tap address picks the stage that drives the tap output. The path from the address to the tap has no register, so the tap tracks the address within the same cycle.

The build-time parameters set up the storage in one of three ways:
- **Chained cells.** Up to four cells are linked into a single register of up to 128 stages. A two-level multiplexer tree then picks which cell drives the tap.
- **Split cell.** A single cell acts as two separate 16-stage registers. Each half has its own serial input and its own tap.
- **Registered tap.** An optional output register makes the tap read synchronous, at the cost of one extra cycle of delay.

In every case a dedicated output carries the final stage of the chain, whatever the tap address is. That output is meant to feed further delay elements.

Top module: `srdl_delay_line`

## Requirements
- R1: On a rising clock edge with `ce` high, every stage takes the value of the stage before it, and stage 0 takes `din_a`.
- R2: With `ce` low, no stage changes and the optional output register holds its value, whatever `din_a` and `din_b` do.
- R3: Without the output register, the tap is a combinational function of the stored stages and `addr_a`: a change of address alone changes `tap_a` within the same cycle, with no clock edge.
- R4: Tap address value N-1 selects stage N. A bit presented on `din_a` therefore shows on `tap_a` after N enabled clock edges.
- R5: `last_out` always shows the final stage of the whole chain (stage 32 × CELLS), whatever the address. With one cell this is stage 32; with four cells it is stage 128.
- R6: With more than one cell, `addr_a[4:0]` selects the stage inside a cell and `addr_a[6:5]` selects the cell. Cell k holds stages 32k+1 to 32k+32. Address values that point past the last built cell read 0.
- R7: With OUT_REG=1, `tap_a` is the combinational tap value captured on an enabled clock edge, so every delay is one cycle longer than in R4.
- R8: Every stage and the output register start at the INIT parameter value (0 by default).
- R9: With SPLIT=1 the cell behaves as two separate 16-stage registers:
  - Half A takes `din_a` and is read through the 4-bit `addr_a`. Half B takes `din_b` and is read through `addr_b`.
  - Both halves use the shared `clk` and `ce`.
  - `last_out` is stage 16 of half A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge |
| ce | input | 1 | Shift enable |
| din_a | input | 1 | Serial input of the chain, or of half A in split mode |
| din_b | input | 1 | Serial input of half B (split mode only) |
| addr_a | input | ADDR_A_W (7 by default) | Tap address of the chain, or of half A |
| addr_b | input | 4 | Tap address of half B (split mode only) |
| tap_a | output | 1 | Selected stage, optionally registered |
| tap_b | output | 1 | Selected stage of half B (0 when not split) |
| last_out | output | 1 | Final stage of the chain, for cascading |

## Verification
The hardest situation to reach is a bit that has travelled through every cell boundary to stage 128 while the enable keeps dropping. Every hold cycle stretches the journey without being allowed to disturb it. The bench drives a long random run in which the enable is high only about three quarters of the time. A queue model of 128 entries predicts every tap, so bits cross all three cell links, and their arrival times depend on both the addresses and the gaps in the enable. Directed phases add a single-bit impulse that is followed tap by tap, a stretch of enable-low cycles with a toggling input, and address sweeps inside one clock phase.

// File: rtl/srdl_pkg.sv
package srdl_pkg;
   localparam int CELL_DEPTH = 32;
   localparam int HALF_DEPTH = CELL_DEPTH / 2;
   localparam int STAGE_W    = $clog2(CELL_DEPTH);
   localparam int HALF_W     = $clog2(HALF_DEPTH);
   localparam int MAX_CELLS  = 4;
endpackage

// File: rtl/srdl_cell.sv
// One storage cell: a plain shift row with no reset, a combinational tap
// and a dedicated output for its final stage.
module srdl_cell #(
   parameter int   DEPTH = srdl_pkg::CELL_DEPTH,
   parameter logic INIT  = 1'b0,
   localparam int  AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          ce,
   input  logic          din,
   input  logic [AW-1:0] addr,
   output logic          tap,
   output logic          last
);
   // Index 0 holds the newest bit. Index N-1 holds the bit from N enabled edges ago.
   logic [DEPTH-1:0] stages = {DEPTH{INIT}};

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("srdl_cell: DEPTH must be a power of two of at least 2");
   end

   always_ff @(posedge clk) begin
      if (ce) stages <= {stages[DEPTH-2:0], din};
   end

   assign tap  = stages[addr];
   assign last = stages[DEPTH-1];
endmodule

// File: rtl/srdl_tap_tree.sv
// Picks one cell tap. Neighbouring pairs are resolved first, then one
// final 2:1 choice. Positions with no cell read as 0.
module srdl_tap_tree #(
   parameter int  CELLS = srdl_pkg::MAX_CELLS,
   localparam int SEL_W = $clog2(CELLS)
) (
   input  logic [CELLS-1:0] taps,
   input  logic [SEL_W-1:0] sel,
   output logic             tap
);
   logic [srdl_pkg::MAX_CELLS-1:0] padded;
   logic [1:0]                     sel2;
   logic [1:0]                     pair;

   if (CELLS < 2 || CELLS > srdl_pkg::MAX_CELLS) begin : g_bad_cells
      $error("srdl_tap_tree: CELLS must lie in 2..4");
   end

   always_comb begin
      padded              = '0;
      padded[CELLS-1:0]   = taps;
   end

   assign sel2 = 2'(sel);

   for (genvar p = 0; p < 2; p++) begin : g_pair
      assign pair[p] = sel2[0] ? padded[2*p+1] : padded[2*p];
   end

   assign tap = sel2[1] ? pair[1] : pair[0];
endmodule

// File: rtl/srdl_delay_line.sv
// Addressable delay line: either chained 32-stage cells or one split cell,
// with an optional register on the tap.
module srdl_delay_line #(
   parameter int   CELLS    = 4,
   parameter bit   SPLIT    = 1'b0,
   parameter bit   OUT_REG  = 1'b0,
   parameter logic INIT     = 1'b0,
   localparam int  SEL_W    = (CELLS > 1) ? $clog2(CELLS) : 0,
   localparam int  ADDR_A_W = SPLIT ? srdl_pkg::HALF_W : srdl_pkg::STAGE_W + SEL_W
) (
   input  logic                clk,
   input  logic                ce,
   input  logic                din_a,
   input  logic                din_b,
   input  logic [ADDR_A_W-1:0] addr_a,
   input  logic [3:0]          addr_b,
   output logic                tap_a,
   output logic                tap_b,
   output logic                last_out
);
   import srdl_pkg::*;

   logic tap_raw;    // half-A or chain tap before the optional register
   logic tap_b_raw;  // half-B tap before the optional register

   if (CELLS < 1 || CELLS > MAX_CELLS) begin : g_bad_cells
      $error("srdl_delay_line: CELLS must lie in 1..4");
   end
   if (SPLIT && CELLS != 1) begin : g_bad_split
      $error("srdl_delay_line: split mode needs CELLS == 1");
   end

   if (SPLIT) begin : g_split
      logic unused_last_b;

      srdl_cell #(.DEPTH(HALF_DEPTH), .INIT(INIT)) u_half_a (
         .clk (clk),
         .ce  (ce),
         .din (din_a),
         .addr(addr_a),
         .tap (tap_raw),
         .last(last_out)
      );

      srdl_cell #(.DEPTH(HALF_DEPTH), .INIT(INIT)) u_half_b (
         .clk (clk),
         .ce  (ce),
         .din (din_b),
         .addr(addr_b),
         .tap (tap_b_raw),
         .last(unused_last_b)
      );
   end else begin : g_chain
      logic [CELLS-1:0] cell_tap;
      logic [CELLS:0]   link;
      logic             unused_b_inputs;

      assign link[0]         = din_a;
      assign unused_b_inputs = ^{din_b, addr_b};

      for (genvar k = 0; k < CELLS; k++) begin : g_cell
         srdl_cell #(.DEPTH(CELL_DEPTH), .INIT(INIT)) u_cell (
            .clk (clk),
            .ce  (ce),
            .din (link[k]),
            .addr(addr_a[STAGE_W-1:0]),
            .tap (cell_tap[k]),
            .last(link[k+1])
         );
      end

      if (CELLS == 1) begin : g_single
         assign tap_raw = cell_tap[0];
      end else begin : g_tree
         srdl_tap_tree #(.CELLS(CELLS)) u_tree (
            .taps(cell_tap),
            .sel (addr_a[ADDR_A_W-1:STAGE_W]),
            .tap (tap_raw)
         );
      end

      assign tap_b_raw = 1'b0;
      assign last_out  = link[CELLS];
   end

   if (OUT_REG) begin : g_oreg
      logic tap_a_q = INIT;
      logic tap_b_q = INIT;

      always_ff @(posedge clk) begin
         if (ce) begin
            tap_a_q <= tap_raw;
            tap_b_q <= tap_b_raw;
         end
      end

      assign tap_a = tap_a_q;
      assign tap_b = tap_b_q;
   end else begin : g_comb
      assign tap_a = tap_raw;
      assign tap_b = tap_b_raw;
   end
endmodule

// File: rtl/srdl_delay_chk.sv
// Timing checks, attached to every instance of the delay line.
module srdl_delay_chk #(
   parameter int ADDR_A_W = 7,
   parameter bit SPLIT    = 1'b0,
   parameter bit OUT_REG  = 1'b0
) (
   input logic                clk,
   input logic                ce,
   input logic                din_a,
   input logic                din_b,
   input logic [ADDR_A_W-1:0] addr_a,
   input logic [3:0]          addr_b,
   input logic                tap_raw,
   input logic                tap_b_raw,
   input logic                tap_a,
   input logic                last_out
);
   // No reset exists, so checks start only after the first edge.
   logic warm = 1'b0;
   always_ff @(posedge clk) warm <= 1'b1;

   assert_first_stage_R1: assert property (@(posedge clk) disable iff (!warm)
      ce |=> ((addr_a != '0) || (tap_raw == $past(din_a))));

   assert_hold_last_R2: assert property (@(posedge clk) disable iff (!warm)
      !ce |=> $stable(last_out));

   // R3: with nothing shifting, the same address must give the same tap.
   assert_stable_tap_R3: assert property (@(posedge clk) disable iff (!warm)
      !ce |=> (!$stable(addr_a) || $stable(tap_raw)));

   if (OUT_REG) begin : g_reg_chk
      assert_reg_capture_R7: assert property (@(posedge clk) disable iff (!warm)
         ce |=> (tap_a == $past(tap_raw)));
      assert_reg_hold_R2: assert property (@(posedge clk) disable iff (!warm)
         !ce |=> $stable(tap_a));
   end

   if (SPLIT) begin : g_split_chk
      assert_half_b_first_R9: assert property (@(posedge clk) disable iff (!warm)
         ce |=> ((addr_b != 4'd0) || (tap_b_raw == $past(din_b))));
   end
endmodule

bind srdl_delay_line srdl_delay_chk #(
   .ADDR_A_W(ADDR_A_W),
   .SPLIT   (SPLIT),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk      (clk),
   .ce       (ce),
   .din_a    (din_a),
   .din_b    (din_b),
   .addr_a   (addr_a),
   .addr_b   (addr_b),
   .tap_raw  (tap_raw),
   .tap_b_raw(tap_b_raw),
   .tap_a    (tap_a),
   .last_out (last_out)
);

// File: tb/srdl_delay_line_tb_top.sv
module srdl_delay_line_tb_top;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic       ce = 1'b0, din_a = 1'b0, din_b = 1'b0;
   logic [6:0] addr_m = '0;
   logic [4:0] addr_r = '0;
   logic [3:0] addr_sa = '0, addr_sb = '0;

   logic tap_m, tapb_m, last_m;
   logic tap_r, tapb_r, last_r;
   logic tap_sa, tap_sb, last_s;

   srdl_delay_line dut_i (
      .clk(clk), .ce(ce), .din_a(din_a), .din_b(1'b0), .addr_a(addr_m),
      .addr_b(4'd0), .tap_a(tap_m), .tap_b(tapb_m), .last_out(last_m));

   srdl_delay_line #(.CELLS(1), .OUT_REG(1'b1)) dut_reg_i (
      .clk(clk), .ce(ce), .din_a(din_a), .din_b(1'b0), .addr_a(addr_r),
      .addr_b(4'd0), .tap_a(tap_r), .tap_b(tapb_r), .last_out(last_r));

   srdl_delay_line #(.CELLS(1), .SPLIT(1'b1)) dut_split_i (
      .clk(clk), .ce(ce), .din_a(din_a), .din_b(din_b), .addr_a(addr_sa),
      .addr_b(addr_sb), .tap_a(tap_sa), .tap_b(tap_sb), .last_out(last_s));

   // Reference queues: index 0 is the newest bit.
   logic hist_a [128];
   logic hist_b [16];
   logic exp_reg;
   int   total = 0;
   int   bad   = 0;

   task automatic check(input logic got, input logic exp, input string tag);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s at %0t: got=%b expected=%b", tag, $time, got, exp);
      end
   endtask

   function automatic string main_tag(input logic [6:0] a);
      return (a >= 7'd32) ? "R6 chained tap" : "R4 tap delay";
   endfunction

   // One clock: drive after the falling edge, check, then advance the model.
   task automatic step(input logic da, input logic db, input logic c,
                       input logic [6:0] am, input logic [4:0] ar,
                       input logic [3:0] sa, input logic [3:0] sb);
      @(negedge clk);
      din_a = da; din_b = db; ce = c;
      addr_m = am; addr_r = ar; addr_sa = sa; addr_sb = sb;
      #1;
      check(tap_m, hist_a[am], main_tag(am));
      check(last_m, hist_a[127], "R5 last of four cells");
      check(tap_r, exp_reg, "R7 registered tap");
      check(last_r, hist_a[31], "R5 last of one cell");
      check(tap_sa, hist_a[sa], "R9 split half A");
      check(tap_sb, hist_b[sb], "R9 split half B");
      check(last_s, hist_a[15], "R9 split last");
      if (c) begin
         exp_reg = hist_a[ar];
         for (int i = 127; i > 0; i--) hist_a[i] = hist_a[i-1];
         hist_a[0] = da;
         for (int i = 15; i > 0; i--) hist_b[i] = hist_b[i-1];
         hist_b[0] = db;
      end
   endtask

   // Change only the address within one low phase; the tap must follow at once.
   task automatic probe(input logic [6:0] a0, input logic [6:0] a1, input logic [6:0] a2);
      @(negedge clk);
      ce = 1'b0;
      addr_m = a0; #1; check(tap_m, hist_a[a0], "R3 comb tap");
      addr_m = a1; #1; check(tap_m, hist_a[a1], "R3 comb tap");
      addr_m = a2; #1; check(tap_m, hist_a[a2], "R3 comb tap");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20250417));
      foreach (hist_a[i]) hist_a[i] = 1'b0;
      foreach (hist_b[i]) hist_b[i] = 1'b0;
      exp_reg = 1'b0;

      #1;
      check(tap_m, 1'b0, "R8 initial tap");
      check(last_m, 1'b0, "R8 initial last");
      check(tap_r, 1'b0, "R8 initial register");
      check(tap_sb, 1'b0, "R8 initial half B");

      // R4: a single impulse followed through the stages with a matching address.
      step(1'b1, 1'b1, 1'b1, 7'd0, 5'd0, 4'd0, 4'd0);
      for (int n = 1; n <= 40; n++)
         step(1'b0, 1'b0, 1'b1, 7'(n - 1), 5'((n - 1) % 32), 4'((n - 1) % 16), 4'((n - 1) % 16));

      // R2: enable low while the inputs toggle.
      for (int n = 0; n < 20; n++)
         step(n[0], ~n[0], 1'b0, 7'(n * 5), 5'(n), 4'(n), 4'(n + 3));

      // R3: address changes with no clock edge.
      probe(7'd0, 7'd27, 7'd40);
      probe(7'd127, 7'd64, 7'd96);

      // Random run: the enable is high about 3/4 of the time.
      for (int n = 0; n < 4000; n++)
         step(1'($urandom), 1'($urandom), ($urandom % 4) != 0,
              7'($urandom), 5'($urandom), 4'($urandom), 4'($urandom));

      // R5 and R6: corner addresses at the cell boundaries.
      step(1'b1, 1'b0, 1'b1, 7'd31, 5'd31, 4'd15, 4'd15);
      step(1'b0, 1'b1, 1'b1, 7'd32, 5'd31, 4'd15, 4'd0);
      step(1'b1, 1'b0, 1'b1, 7'd95, 5'd0, 4'd0, 4'd15);
      step(1'b0, 1'b1, 1'b1, 7'd127, 5'd31, 4'd15, 4'd15);
      probe(7'd63, 7'd64, 7'd127);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule